// File: doc/BRIEF.md
# SCSI DMA Transfer Length Controller

This block sits beside a SCSI bus controller's register file and decides how many bytes a transfer-information DMA moves. When a transfer starts it reads a 16-bit transfer counter and a signed remaining device byte count, and emits a single burst length. A positive remaining count means data flows from the device; a negative one means data flows toward it. It then follows the device buffers handed to it, one buffer at a time. For each buffer it issues a move length, updates the remaining count, and decides whether the transfer is complete.

On completion the block writes a fixed pattern into the status, interrupt, sequence-step, FIFO-flag and counter registers and raises the interrupt. It also holds back select commands while the external DMA enable is low. A select issued then is replayed once when the enable rises. The memory bus master that actually moves the bytes sits outside the block.

Top module: `xfer_len_ctrl`

## Requirements
- R1: After reset, cnt, stat, intr, seq, fflags, remain and irq are all zero, and sel_pending and sel_go are low.
- R2: A write of the counter (cnt_we) loads wdata into cnt and clears the terminal-count bit, stat[4].
- R3: On ti_start with cmd_phase low, burst_valid pulses in the next cycle. burst_len is then the smaller of the counter span and the magnitude of remain, where a counter of 0 counts as 65536.
- R4: On ti_start with cmd_phase high, burst_valid and cmd_fetch pulse in the next cycle with burst_len equal to the smaller of the counter span and 32, and no data transfer becomes active.
- R5: ti_start clears stat[4].
- R6: A buffer event (buf_valid, buf_len nonzero) during an active transfer with bytes left moves the smaller of the bytes left and buf_len. That value appears on mv_len with mv_valid in the next cycle. remain grows by it when remain is negative (toward the device) and shrinks by it otherwise.
- R7: A buffer that is only partly consumed (buf_len larger than the bytes moved) completes the transfer at once.
- R8: A fully consumed buffer completes the transfer only when the data flows from the device, no bytes remain in the burst, and remain is still above zero; a fully consumed buffer toward the device never completes it.
- R9: A buffer event during an active transfer with no burst bytes left completes the transfer when remain is zero or negative, and otherwise does nothing.
- R10: On completion, stat becomes 0x90 (bit 7 mirrors irq, bit 4 is terminal count). intr becomes 0x10, seq, fflags and cnt become zero, irq goes high, and later buffer events are ignored until the next ti_start.
- R11: irq_ack clears irq, stat[7] and intr while keeping stat[4].
- R12: sel_req while dma_en is high gives sel_go in the next cycle with sel_go_kind equal to sel_kind.
- R13: sel_req while dma_en is low sets sel_pending and stores the kind, a later request replacing the stored one. The stored kind issues one sel_go in the cycle after dma_en rises, and sel_pending then clears.
- R14: Reset discards a pending select, so a later rise of dma_en issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| wdata | input | 16 | Write data: counter value, or fflags in [4:0] and seq in [10:8] |
| cnt_we | input | 1 | Load transfer counter from wdata |
| aux_we | input | 1 | Load fflags and seq from wdata |
| rem_we | input | 1 | Load remaining device count |
| rem_wdata | input | RW | Signed remaining count to load |
| cmd_phase | input | 1 | Command phase flag |
| ti_start | input | 1 | Start transfer-information DMA |
| buf_valid | input | 1 | Device buffer available |
| buf_len | input | 17 | Bytes in that buffer |
| irq_ack | input | 1 | Acknowledge the interrupt |
| dma_en | input | 1 | External DMA enable |
| sel_req | input | 1 | Select command request |
| sel_kind | input | 2 | Select command variant |
| burst_valid | output | 1 | Burst length valid |
| burst_len | output | 17 | Computed burst length |
| cmd_fetch | output | 1 | Burst is a command fetch |
| mv_valid | output | 1 | Move issued |
| mv_len | output | 17 | Bytes in the move |
| to_device | output | 1 | remain is negative |
| remain | output | RW | Signed remaining device count |
| cnt | output | 16 | Transfer counter |
| stat | output | 8 | Status register |
| intr | output | 8 | Interrupt register |
| seq | output | 3 | Sequence step |
| fflags | output | 5 | FIFO flags |
| irq | output | 1 | Interrupt |
| sel_go | output | 1 | Issue select |
| sel_go_kind | output | 2 | Variant of issued select |
| sel_pending | output | 1 | A select is held |

## Verification
The bench drives a zero counter against a large remaining count to check the 65536 case. A design that took zero literally would return a zero burst. It also drives the command-phase clamp with both a small and a zero counter; a missing clamp would show a burst larger than 32. Random buffers push the block through partial buffers, exactly drained reads with and without remaining device data, and writes toward the device. Getting the completion rule wrong there shows up as an early or missing irq, or a wrong remaining count. The select gating is checked for a replay of the newest held request exactly once, and for the discard of a held request by reset. A design that kept a stale request would issue a spurious sel_go.

// File: rtl/xfer_len_ctrl.sv
module xfer_len_ctrl #(
  parameter int CW = 16,
  parameter int RW = 24,
  parameter int CMDMAX = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        wdata,
  input  logic                 cnt_we,
  input  logic                 aux_we,
  input  logic                 rem_we,
  input  logic signed [RW-1:0] rem_wdata,
  input  logic                 cmd_phase,
  input  logic                 ti_start,
  input  logic                 buf_valid,
  input  logic [CW:0]          buf_len,
  input  logic                 irq_ack,
  input  logic                 dma_en,
  input  logic                 sel_req,
  input  logic [1:0]           sel_kind,
  output logic                 burst_valid,
  output logic [CW:0]          burst_len,
  output logic                 cmd_fetch,
  output logic                 mv_valid,
  output logic [CW:0]          mv_len,
  output logic                 to_device,
  output logic signed [RW-1:0] remain,
  output logic [CW-1:0]        cnt,
  output logic [7:0]           stat,
  output logic [7:0]           intr,
  output logic [2:0]           seq,
  output logic [4:0]           fflags,
  output logic                 irq,
  output logic                 sel_go,
  output logic [1:0]           sel_go_kind,
  output logic                 sel_pending
);
  localparam int LW = CW + 1;

  logic          tc_q, active_q, en_q;
  logic [LW-1:0] left_q;
  logic [1:0]    pkind_q;

  logic [LW-1:0] span, len_cmd, len_data, mv, left_n;
  logic [RW-1:0] span_w, abs_rem;
  logic signed [RW-1:0] mv_s, rem_n;
  logic          rem_pos, rem_n_pos, take_buf, done;

  assign span      = (cnt == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, cnt};
  assign span_w    = RW'(span);
  assign abs_rem   = remain[RW-1] ? RW'(-remain) : RW'(remain);
  assign len_data  = LW'((span_w < abs_rem) ? span_w : abs_rem);
  assign len_cmd   = (span < LW'(CMDMAX)) ? span : LW'(CMDMAX);
  assign to_device = remain[RW-1];
  assign rem_pos   = !remain[RW-1] && (remain != '0);

  assign take_buf  = !ti_start && buf_valid && active_q && (buf_len != '0);
  assign mv        = (left_q < buf_len) ? left_q : buf_len;
  assign left_n    = left_q - mv;
  assign mv_s      = $signed(RW'(mv));
  assign rem_n     = to_device ? remain + mv_s : remain - mv_s;
  assign rem_n_pos = !rem_n[RW-1] && (rem_n != '0);

  always_comb begin
    done = 1'b0;
    if (take_buf) begin
      if (left_q == '0)
        done = !rem_pos;
      else
        done = (buf_len != mv) || (!to_device && (left_n == '0) && rem_n_pos);
    end
  end

  assign stat = {irq, 2'b00, tc_q, 4'b0000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; tc_q <= 1'b0; irq <= 1'b0; intr <= '0; seq <= '0; fflags <= '0;
      remain <= '0; left_q <= '0; active_q <= 1'b0;
      burst_valid <= 1'b0; burst_len <= '0; cmd_fetch <= 1'b0;
      mv_valid <= 1'b0; mv_len <= '0;
    end else begin
      burst_valid <= 1'b0;
      cmd_fetch   <= 1'b0;
      mv_valid    <= 1'b0;
      if (cnt_we) begin
        cnt  <= wdata;
        tc_q <= 1'b0;
      end
      if (aux_we) begin
        fflags <= wdata[4:0];
        seq    <= wdata[10:8];
      end
      if (rem_we) remain <= rem_wdata;
      if (irq_ack) begin
        irq  <= 1'b0;
        intr <= '0;
      end
      if (ti_start) begin
        tc_q        <= 1'b0;
        burst_valid <= 1'b1;
        if (cmd_phase) begin
          burst_len <= len_cmd;
          cmd_fetch <= 1'b1;
        end else begin
          burst_len <= len_data;
          left_q    <= len_data;
          active_q  <= 1'b1;
        end
      end else if (take_buf && left_q != '0) begin
        mv_valid <= 1'b1;
        mv_len   <= mv;
        left_q   <= left_n;
        remain   <= rem_n;
      end
      if (done) begin
        tc_q     <= 1'b1;
        irq      <= 1'b1;
        intr     <= 8'h10;
        seq      <= '0;
        fflags   <= '0;
        cnt      <= '0;
        active_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; sel_pending <= 1'b0; pkind_q <= '0;
      sel_go <= 1'b0; sel_go_kind <= '0;
    end else begin
      en_q   <= dma_en;
      sel_go <= 1'b0;
      if (dma_en) begin
        if (sel_req) begin
          sel_go      <= 1'b1;
          sel_go_kind <= sel_kind;
          sel_pending <= 1'b0;
        end else if (!en_q && sel_pending) begin
          sel_go      <= 1'b1;
          sel_go_kind <= pkind_q;
          sel_pending <= 1'b0;
        end
      end else if (sel_req) begin
        sel_pending <= 1'b1;
        pkind_q     <= sel_kind;
      end
    end
  end

  assert_cmd_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fetch |-> (burst_len <= LW'(CMDMAX) && burst_len != '0));
  assert_move_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> (mv_len <= $past(buf_len) && mv_len != '0));
  assert_done_regs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (intr == 8'h10 && cnt == '0 && stat[4] && seq == '0 && fflags == '0));
  assert_go_needs_en_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sel_go |-> $past(dma_en));
  assert_go_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
    sel_go |-> !sel_pending);
endmodule

// File: tb/test_xfer_len_ctrl.sv
module test_xfer_len_ctrl;
  localparam int RW = 24;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] wdata = '0;
  logic cnt_we = 0, aux_we = 0, rem_we = 0, cmd_phase = 0, ti_start = 0, buf_valid = 0;
  logic signed [RW-1:0] rem_wdata = '0;
  logic [16:0] buf_len = '0;
  logic irq_ack = 0, dma_en = 0, sel_req = 0;
  logic [1:0] sel_kind = '0;
  logic burst_valid, cmd_fetch, mv_valid, to_device, irq, sel_go, sel_pending;
  logic [16:0] burst_len, mv_len;
  logic signed [RW-1:0] remain;
  logic [15:0] cnt;
  logic [7:0] stat, intr;
  logic [2:0] seq;
  logic [4:0] fflags;
  logic [1:0] sel_go_kind;

  int checks = 0, errors = 0;
  bit finished = 0;
  int m_left, m_rem;
  bit m_active;

  xfer_len_ctrl #(.RW(RW)) i_xfer_len_ctrl (.*);

  always #10 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int span_of(int c);
    return (c == 0) ? 65536 : c;
  endfunction
  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction
  function automatic int iabs(int a);
    return (a < 0) ? -a : a;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic wr_cnt(int v);
    @(negedge clk); wdata = 16'(v); cnt_we = 1;
    @(negedge clk); cnt_we = 0;
  endtask
  task automatic wr_aux(int f, int s);
    @(negedge clk); wdata = 16'((s << 8) | f); aux_we = 1;
    @(negedge clk); aux_we = 0;
  endtask
  task automatic wr_rem(int v);
    @(negedge clk); rem_wdata = RW'(v); rem_we = 1;
    @(negedge clk); rem_we = 0;
    m_rem = v;
  endtask

  task automatic start(bit cp, int c, int r);
    int exp;
    wr_cnt(c); wr_rem(r);
    @(negedge clk); cmd_phase = cp; ti_start = 1;
    @(negedge clk); ti_start = 0;
    exp = cp ? imin(span_of(c), 32) : imin(span_of(c), iabs(r));
    chk(cp ? "R4 burst_len" : "R3 burst_len", int'(burst_len), exp);
    chk("R3 burst_valid", int'(burst_valid), 1);
    chk("R4 cmd_fetch", int'(cmd_fetch), int'(cp));
    chk("R5 tc cleared", int'(stat[4]), 0);
    if (!cp) begin m_left = exp; m_active = 1; end
  endtask

  task automatic check_done();
    chk("R10 stat", int'(stat), 8'h90);
    chk("R10 intr", int'(intr), 8'h10);
    chk("R10 seq", int'(seq), 0);
    chk("R10 fflags", int'(fflags), 0);
    chk("R10 cnt", int'(cnt), 0);
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    chk("R11 irq", int'(irq), 0);
    chk("R11 stat", int'(stat), 8'h10);
    chk("R11 intr", int'(intr), 0);
  endtask

  task automatic feed(int bl, output bit done);
    int mv, l2, r2;
    bit td;
    done = 0; mv = 0; l2 = m_left; r2 = m_rem;
    if (m_left == 0) done = (m_rem <= 0);
    else begin
      mv = imin(m_left, bl); td = (m_rem < 0);
      l2 = m_left - mv; r2 = td ? m_rem + mv : m_rem - mv;
      done = (bl > mv) || (!td && l2 == 0 && r2 > 0);
    end
    @(negedge clk); buf_valid = 1; buf_len = 17'(bl);
    @(negedge clk); buf_valid = 0;
    chk("R6 mv_valid", int'(mv_valid), int'(mv != 0));
    if (mv != 0) chk("R6 mv_len", int'(mv_len), mv);
    chk("R6 remain", int'(remain), r2);
    chk(done ? "R7 R8 R9 irq" : "R8 R9 no irq", int'(irq), int'(done));
    m_left = l2; m_rem = r2;
    if (done) begin m_active = 0; check_done(); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit d;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 stat", int'(stat), 0); chk("R1 intr", int'(intr), 0);
    chk("R1 cnt", int'(cnt), 0); chk("R1 irq", int'(irq), 0);
    chk("R1 remain", int'(remain), 0); chk("R1 seq", int'(seq), 0);
    chk("R1 fflags", int'(fflags), 0);
    chk("R1 pending", int'(sel_pending), 0); chk("R1 go", int'(sel_go), 0);

    start(0, 0, -70000);
    start(0, 0, 100);
    start(0, 5, -3);
    start(1, 0, 0);
    start(1, 7, 0);

    wr_aux(5'h15, 3);
    start(0, 10, 50);
    feed(4, d);
    feed(20, d);
    wr_cnt(9);
    chk("R2 cnt", int'(cnt), 9);
    chk("R2 tc", int'(stat[4]), 0);
    @(negedge clk); buf_valid = 1; buf_len = 17'd5;
    @(negedge clk); buf_valid = 0;
    chk("R10 ignored mv", int'(mv_valid), 0);
    chk("R10 ignored remain", int'(remain), m_rem);

    start(0, 8, -8);
    feed(8, d);
    feed(3, d);

    for (int t = 0; t < 300; t++) begin
      int c, r;
      c = ($urandom % 10 == 0) ? 0 : 1 + int'($urandom % 200);
      r = int'($urandom % 601) - 300;
      wr_aux(int'($urandom % 32), int'($urandom % 8));
      start(0, c, r);
      for (int e = 0; e < 6; e++) begin
        if (!m_active || (m_left == 0 && m_rem > 0)) break;
        feed(1 + int'($urandom % 150), d);
      end
    end

    do_reset();
    @(negedge clk); dma_en = 1; sel_req = 1; sel_kind = 2;
    @(negedge clk); sel_req = 0;
    chk("R12 go", int'(sel_go), 1); chk("R12 kind", int'(sel_go_kind), 2);
    @(negedge clk); dma_en = 0; sel_req = 1; sel_kind = 1;
    @(negedge clk); sel_kind = 3;
    @(negedge clk); sel_req = 0;
    chk("R13 pending", int'(sel_pending), 1); chk("R13 no go", int'(sel_go), 0);
    @(negedge clk); dma_en = 1;
    @(negedge clk);
    chk("R13 go", int'(sel_go), 1); chk("R13 kind", int'(sel_go_kind), 3);
    chk("R13 cleared", int'(sel_pending), 0);
    @(negedge clk);
    chk("R13 once", int'(sel_go), 0);
    @(negedge clk); dma_en = 0; sel_req = 1; sel_kind = 1;
    @(negedge clk); sel_req = 0;
    do_reset();
    chk("R14 pending", int'(sel_pending), 0);
    @(negedge clk); dma_en = 1;
    @(negedge clk);
    chk("R14 no go", int'(sel_go), 0);
    @(negedge clk);
    chk("R14 no go later", int'(sel_go), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule